// File: doc/BRIEF.md
# Periodic Tick Backlog Counter

This block turns a programmed reload count into a stream of periodic tick interrupts. It makes sure no tick is lost when the consumer of those ticks is stalled. The period of each tick is measured on a free-running time base that the block receives as an input.

On every clock the block compares the time base with the time of the next scheduled tick. When one or more ticks have come due, it adds all of them to a backlog counter in a single step and moves the schedule forward by whole periods. The interrupt request stays high while the backlog is nonzero. An acknowledge pulse consumes one tick. The first acknowledge after a reload instead discards the whole backlog, since that backlog was built up under the old setting. A re-inject pulse returns a tick that was taken but never delivered.

Top module: `tick_backlog`

## Requirements
- R1: After reset the backlog is 0, the request is low and the next due time reads 0. No tick is counted before the first load, whatever the time base does.
- R2: A load sets the tick period to the 16-bit reload value in time-base units. A reload value of 0 selects a period of 65536.
- R3: A period below MIN_PERIOD (default 1074) is replaced by FLOOR_PERIOD (default 1193). A period exactly equal to MIN_PERIOD is kept unchanged.
- R4: A load sets the next due time to the time base on the load cycle plus the period.
- R5: A due check happens on every clock after a load. Let d = time_now + SLOP - next_due, computed modulo 2^32 (SLOP default 4). When d, read as a signed number, is not negative, the block adds d/period + 1 ticks to the backlog at once, and next_due advances by that number times the period. When d is negative, next_due does not move.
- R6: The first acknowledge after a load clears the backlog to 0 and marks the first injection as done.
- R7: Each later acknowledge lowers the backlog by one. It never goes below 0.
- R8: A re-inject pulse raises the backlog by one.
- R9: The backlog saturates at 2^PEND_W - 1 (63 by default) and never wraps.
- R10: The request output is high exactly when the backlog is nonzero.
- R11: Events in the same cycle combine in a fixed order: the acknowledge is applied first, then the re-inject and any newly due ticks are added. A load cycle makes no due check. A load clears the first-injection mark, even when an acknowledge arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Strobe that takes a new reload value |
| reload | input | 16 | Reload count; 0 means 65536 |
| time_now | input | 32 | Free-running time base |
| inj_ack | input | 1 | A tick interrupt was accepted |
| reinj | input | 1 | A taken tick must be delivered again |
| pend_cnt | output | 6 | Number of ticks not yet delivered |
| irq | output | 1 | Tick interrupt request |
| next_due | output | 32 | Scheduled time of the next tick |

## Verification
The time base is advanced in several ways. Single small steps approach the due time and show the exact cycle that the slop makes due. A large jump must add several ticks and advance the schedule by a multiple of the period. A jump across the 32-bit wrap shows that the comparison is modulo. Reloads of 0, of a value below the minimum, of the value just under the minimum and of the exact minimum separate the period rules from one another. Acknowledge and re-inject pulses arrive alone, on an empty backlog, on a full backlog and together with a due tick or a load. These cases tell apart the first-acknowledge clear, the decrement floor, saturation and the same-cycle ordering.

// File: rtl/tick_backlog.sv
module tick_backlog #(
  parameter int CNT_W        = 16,
  parameter int TIME_W       = 32,
  parameter int PEND_W       = 6,
  parameter int MIN_PERIOD   = 1074,
  parameter int FLOOR_PERIOD = 1193,
  parameter int SLOP         = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  reload,
  input  logic [TIME_W-1:0] time_now,
  input  logic              inj_ack,
  input  logic              reinj,
  output logic [PEND_W-1:0] pend_cnt,
  output logic              irq,
  output logic [TIME_W-1:0] next_due
);
  localparam int PER_W = CNT_W + 1;
  localparam int SUM_W = TIME_W + 2;
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [PER_W-1:0]  raw_per, new_per, period_q;
  logic [TIME_W-1:0] per_ext, diff, missed, advance;
  logic [PEND_W-1:0] after_ack;
  logic [SUM_W-1:0]  sum;
  logic              armed_q, first_q, due_w;

  assign raw_per = (reload == '0) ? PER_W'(1 << CNT_W) : PER_W'(reload);
  assign new_per = (raw_per < PER_W'(MIN_PERIOD)) ? PER_W'(FLOOR_PERIOD) : raw_per;
  assign per_ext = TIME_W'(period_q);

  assign diff    = time_now + TIME_W'(SLOP) - next_due;
  assign due_w   = armed_q && !load && !diff[TIME_W-1];
  assign missed  = due_w ? (diff / per_ext) + TIME_W'(1) : '0;
  assign advance = missed * per_ext;

  assign after_ack = !inj_ack                ? pend_cnt :
                     !first_q                ? '0 :
                     (pend_cnt != '0)        ? pend_cnt - PEND_W'(1) : pend_cnt;

  assign sum = SUM_W'(after_ack) + SUM_W'(reinj) + SUM_W'(missed);
  assign irq = (pend_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_cnt <= '0;
      next_due <= '0;
      period_q <= PER_W'(FLOOR_PERIOD);
      armed_q  <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      pend_cnt <= (sum > SUM_W'(PEND_MAX)) ? PEND_MAX : sum[PEND_W-1:0];
      if (load) begin
        period_q <= new_per;
        next_due <= time_now + TIME_W'(new_per);
        armed_q  <= 1'b1;
        first_q  <= 1'b0;
      end else begin
        if (due_w) next_due <= next_due + advance;
        if (inj_ack) first_q <= 1'b1;
      end
    end
  end
endmodule

module tick_backlog_chk #(
  parameter int TIME_W     = 32,
  parameter int PEND_W     = 6,
  parameter int PER_W      = 17,
  parameter int MIN_PERIOD = 1074
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              inj_ack,
  input logic              reinj,
  input logic [PEND_W-1:0] pend_cnt,
  input logic [TIME_W-1:0] next_due,
  input logic [PER_W-1:0]  period_q,
  input logic              first_q,
  input logic              due_w
);
  localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};

  a_r3_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
    period_q >= PER_W'(MIN_PERIOD));

  a_r5_due_moves: assert property (@(posedge clk) disable iff (!rst_n)
    due_w |=> next_due != $past(next_due));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!due_w && !load) |=> $stable(next_due));

  a_r6_first_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!first_q && inj_ack && !reinj && !due_w) |=> pend_cnt == '0);

  a_r7_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q && inj_ack && !reinj && !due_w) |=>
      pend_cnt == (($past(pend_cnt) != '0) ? $past(pend_cnt) - PEND_W'(1) : '0));

  a_r8_reinject: assert property (@(posedge clk) disable iff (!rst_n)
    (reinj && !inj_ack && !due_w) |=>
      pend_cnt == (($past(pend_cnt) == PMAX) ? PMAX : $past(pend_cnt) + PEND_W'(1)));

  a_r11_load_clears_first: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !first_q);
endmodule

bind tick_backlog tick_backlog_chk #(
  .TIME_W(TIME_W), .PEND_W(PEND_W), .PER_W(PER_W), .MIN_PERIOD(MIN_PERIOD)
) u_chk (.*);

// File: tb/test_tick_backlog.sv
`timescale 1ns/1ps
module test_tick_backlog;
  localparam longint MASK = 64'hFFFF_FFFF;

  typedef struct {
    int          pend;
    logic [31:0] due;
    string       tag;
  } exp_t;

  logic        clk = 0, rst_n = 0, load = 0, inj_ack = 0, reinj = 0;
  logic [15:0] reload = 0;
  logic [31:0] time_now = 0;
  logic [5:0]  pend_cnt;
  logic        irq;
  logic [31:0] next_due;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t q[$];

  longint m_pend = 0, m_per = 1193, m_due = 0;
  bit     m_armed = 0, m_first = 0;

  always #5 clk = ~clk;

  tick_backlog i_tick_backlog (
    .clk(clk), .rst_n(rst_n), .load(load), .reload(reload), .time_now(time_now),
    .inj_ack(inj_ack), .reinj(reinj), .pend_cnt(pend_cnt), .irq(irq), .next_due(next_due)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit ld, input int rv, input longint t, input bit ack,
                      input bit ri, input string tag);
    longint d, missed, after, np, per;
    bit due;
    exp_t e;
    @(negedge clk);
    load = ld; reload = rv[15:0]; time_now = t[31:0]; inj_ack = ack; reinj = ri;
    d = (t + 4 - m_due) & MASK;
    due = m_armed && !ld && (d < 64'h8000_0000);
    missed = due ? d / m_per + 1 : 0;
    if (!ack) after = m_pend;
    else if (!m_first) after = 0;
    else after = (m_pend > 0) ? m_pend - 1 : 0;
    np = after + ri + missed;
    if (np > 63) np = 63;
    if (ld) begin
      per = (rv == 0) ? 65536 : rv;
      if (per < 1074) per = 1193;
      m_per = per; m_due = (t + per) & MASK; m_armed = 1; m_first = 0;
    end else begin
      if (due) m_due = (m_due + missed * m_per) & MASK;
      if (ack) m_first = 1;
    end
    m_pend = np;
    e.pend = int'(np); e.due = m_due[31:0]; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      #1;
      e = q.pop_front();
      chk(e.tag, "pend_cnt", pend_cnt, e.pend);
      chk(e.tag, "next_due", next_due, e.due);
      chk("R10", "irq", irq, e.pend != 0);
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset pend", pend_cnt, 0);
    chk("R1", "reset irq", irq, 0);
    chk("R1", "reset due", next_due, 0);
    step(0, 0, 50000, 0, 0, "R1");
    step(0, 0, 90000, 0, 0, "R1");
    // R2 R4: load 2000 at time 100
    step(1, 2000, 100, 0, 0, "R4");
    step(0, 0, 2095, 0, 0, "R5");
    step(0, 0, 2096, 0, 0, "R5");
    step(0, 0, 9000, 0, 0, "R5");
    step(0, 0, 9001, 1, 0, "R6");
    step(0, 0, 9002, 0, 1, "R8");
    step(0, 0, 9003, 1, 0, "R7");
    step(0, 0, 9004, 1, 0, "R7");
    step(0, 0, 10096, 0, 0, "R5");
    step(0, 0, 12096, 1, 0, "R11");
    step(1, 0, 13000, 1, 0, "R11");
    step(0, 0, 78531, 0, 0, "R2");
    step(0, 0, 78532, 0, 0, "R2");
    step(0, 0, 78533, 1, 0, "R6");
    step(1, 500, 80000, 0, 0, "R3");
    step(1, 1073, 80001, 0, 0, "R3");
    step(1, 1074, 80002, 0, 0, "R3");
    step(0, 0, 80002 + 1074*100, 0, 0, "R9");
    step(0, 0, 80003 + 1074*100, 0, 1, "R9");
    step(1, 8192, 64'hFFFF_F000, 0, 0, "R4");
    step(0, 0, 64'hFFFF_F001, 1, 0, "R6");
    step(0, 0, 64'h0000_0FFB, 0, 0, "R5");
    step(0, 0, 64'h0000_0FFC, 0, 0, "R5");
    step(0, 0, 64'h0000_0FFD, 0, 1, "R8");
    step(0, 0, 64'h0000_0FFE, 1, 1, "R11");
    step(0, 0, 64'h0000_0FFF, 0, 0, "R10");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule